// File: doc/BRIEF.md
# Low-Power GPIO Controller with Interrupts

This block controls 22 general-purpose pins from a simple 32-bit register port. Each pin has four state bits: an output value, a drive enable, a latched interrupt flag, and an input level that passes through two flops before use. The output value, the drive enable and the interrupt flags can each be written in three ways. A plain write replaces the whole register. A set alias ORs in the bits written as one. A clear alias removes the bits written as one. Software can therefore change single pins without a read-modify-write, and it can raise an interrupt flag by hand as well as acknowledge one.

Every pin has its own configuration word. The word selects push-pull or open-drain drive, one of six trigger conditions, and whether a latched flag on that pin also raises the wakeup line. Edge triggers compare the synchronized level with its value one cycle earlier. Level triggers set the flag again on every cycle that the level holds. The interrupt line is the OR of all flags. The wakeup line is the OR of the flags on pins whose wakeup bit is set.

The bus takes a word index, a write strobe and write data. Reads return data one clock after the request.

Top module: `lp_gpio_ctrl`

## Requirements
- R1: In the output, enable, flag and input registers, pin n sits at data bit 10+n. Bits 9..0 read as 0, and writing them has no effect.
- R2: The output register (word 0) resets to 0. A write to word 0 replaces it. Word 1 ORs in the ones written, and word 2 clears the ones written. Bits written as 0 through word 1 or word 2 keep their value. In push-pull mode pad_o follows this register.
- R3: The drive-enable register (word 3) resets to 0 and has the same three write forms: direct at word 3, set at word 4, clear at word 5.
- R4: The flag register (word 6) resets to 0 and has the same three write forms: direct at word 6, set at word 7, clear at word 8. irq_o is high exactly when any flag is set.
- R5: Trigger code 1 sets the pin flag on a rising edge of the synchronized level, code 2 on a falling edge and code 3 on either edge. A flag, once set, stays set until software clears it.
- R6: Trigger code 4 sets the flag while the level is low and code 5 while it is high. A clear does not remove the flag while the level persists.
- R7: Trigger codes 0, 6 and 7 never set a flag, whatever the pad does.
- R8: Configuration bit 2 set to 1 selects open-drain. In that mode a 1 releases the pad (pad_oe_o low) and a 0 drives it low when the enable is set. Bit 2 set to 0 selects push-pull: pad_oe_o follows the enable and pad_o follows the output value.
- R9: The configuration word of pin n is word 10+n, with the drive mode at bit 2, the trigger code at bits 9..7 and the wakeup enable at bit 10. All other bits read as 0.
- R10: The input register (word 9) is read-only. It shows a pad level two clocks after the change, through a two-flop synchronizer.
- R11: wake_o is high exactly when some pin has its flag set and its wakeup bit set.
- R12: When a hardware trigger and a software clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after a read request |
| pad_i | input | 22 | Pad input levels |
| pad_o | output | 22 | Pad drive value |
| pad_oe_o | output | 22 | Pad drive enable |
| irq_o | output | 1 | OR of all interrupt flags |
| wake_o | output | 1 | OR of the flags on pins with wakeup enabled |

## Verification
The bench builds the block with its default parameters: 22 pins, 32-bit data and a 6-bit word index. With these values every pin register fills exactly bits 31..10, so the reserved low field and the top pin bit are both in reach of a single read. Each configuration word, up to word 31, sits inside the decoded range. The two-flop synchronizer sets the timing. This lets the bench place a software clear in exactly the cycle in which an edge trigger fires, and read the input register one cycle before and one cycle after a pad change becomes visible.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_ANY  = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5,
    TRIG_RSV6 = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_e;

  typedef struct packed {
    logic  wake;
    trig_e trig;
    logic  od;
  } pin_cfg_t;

  localparam int unsigned CFG_OD_BIT   = 2;
  localparam int unsigned CFG_TRIG_LSB = 7;
  localparam int unsigned CFG_WAKE_BIT = 10;

  localparam int unsigned REG_OUT     = 0;
  localparam int unsigned REG_OUT_SET = 1;
  localparam int unsigned REG_OUT_CLR = 2;
  localparam int unsigned REG_OEN     = 3;
  localparam int unsigned REG_OEN_SET = 4;
  localparam int unsigned REG_OEN_CLR = 5;
  localparam int unsigned REG_STA     = 6;
  localparam int unsigned REG_STA_SET = 7;
  localparam int unsigned REG_STA_CLR = 8;
  localparam int unsigned REG_IN      = 9;
  localparam int unsigned REG_CFG0    = 10;
endpackage

// File: rtl/lpg_sync.sv
module lpg_sync #(
  parameter int unsigned WIDTH  = 22,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R10
    end
  endgenerate
endmodule

// File: rtl/lpg_trig.sv
module lpg_trig
  import lpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_e mode_i,
  output logic  hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    case (mode_i)
      TRIG_RISE: hit_o = lvl_i & ~prev_q;
      TRIG_FALL: hit_o = ~lvl_i & prev_q;
      TRIG_ANY:  hit_o = lvl_i ^ prev_q;
      TRIG_LOW:  hit_o = ~lvl_i;
      TRIG_HIGH: hit_o = lvl_i;
      default:   hit_o = 1'b0;
    endcase
  end

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_OFF || mode_i == TRIG_RSV6 || mode_i == TRIG_RSV7) |-> !hit_o); // R7
endmodule

// File: rtl/lpg_pad_drv.sv
module lpg_pad_drv (
  input  logic od_i,
  input  logic val_i,
  input  logic en_i,
  output logic pad_o,
  output logic pad_oe_o
);
  always_comb begin
    if (od_i) begin
      pad_o    = 1'b0;
      pad_oe_o = en_i & ~val_i;
    end else begin
      pad_o    = val_i;
      pad_oe_o = en_i;
    end
  end

  always_comb begin
    if (od_i) AST_OD_NO_HIGH: assert (!(pad_oe_o && pad_o)); // R8
  end
endmodule

// File: rtl/lp_gpio_ctrl.sv
module lp_gpio_ctrl
  import lpg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int unsigned PIN_LSB = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] out_q, oen_q, sta_q;
  logic [NUM_PINS-1:0] pad_sync, hw_set, wake_en;
  pin_cfg_t            cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] wpins;
  logic                wr;
  logic                unused_wbits;

  assign wr           = req_i & we_i;
  assign wpins        = wdata_i[DATA_W-1:PIN_LSB];
  assign unused_wbits = ^{wdata_i[CFG_TRIG_LSB-1:CFG_OD_BIT+1], wdata_i[CFG_OD_BIT-1:0]};

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int unsigned idx);
    return a == ADDR_W'(idx);
  endfunction

  function automatic logic [NUM_PINS-1:0] upd(
    input logic [NUM_PINS-1:0] cur, input logic [NUM_PINS-1:0] v,
    input logic wd, input logic ws, input logic wc);
    if (wd) return v;
    if (ws) return cur | v;
    if (wc) return cur & ~v;
    return cur;
  endfunction

  lpg_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      lpg_trig u_trig (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (pad_sync[i]),
        .mode_i(cfg_q[i].trig),
        .hit_o (hw_set[i])
      );
      lpg_pad_drv u_drv (
        .od_i    (cfg_q[i].od),
        .val_i   (out_q[i]),
        .en_i    (oen_q[i]),
        .pad_o   (pad_o[i]),
        .pad_oe_o(pad_oe_o[i])
      );
      assign wake_en[i] = cfg_q[i].wake;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oen_q <= '0;
      sta_q <= '0;
    end else begin
      out_q <= upd(out_q, wpins, wr & sel(addr_i, REG_OUT),
                   wr & sel(addr_i, REG_OUT_SET), wr & sel(addr_i, REG_OUT_CLR));
      oen_q <= upd(oen_q, wpins, wr & sel(addr_i, REG_OEN),
                   wr & sel(addr_i, REG_OEN_SET), wr & sel(addr_i, REG_OEN_CLR));
      // hardware trigger overrides any software clear
      sta_q <= upd(sta_q, wpins, wr & sel(addr_i, REG_STA),
                   wr & sel(addr_i, REG_STA_SET), wr & sel(addr_i, REG_STA_CLR)) | hw_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_PINS); i++) cfg_q[i] <= '{wake: 1'b0, trig: TRIG_OFF, od: 1'b0};
    end else begin
      for (int i = 0; i < int'(NUM_PINS); i++) begin
        if (wr && sel(addr_i, REG_CFG0 + i)) begin
          cfg_q[i].wake <= wdata_i[CFG_WAKE_BIT];
          cfg_q[i].trig <= trig_e'(wdata_i[CFG_TRIG_LSB +: 3]);
          cfg_q[i].od   <= wdata_i[CFG_OD_BIT];
        end
      end
    end
  end

  logic [DATA_W-1:0] rd_nx;
  always_comb begin
    rd_nx = '0;
    if (sel(addr_i, REG_OUT)) rd_nx[DATA_W-1:PIN_LSB] = out_q;
    if (sel(addr_i, REG_OEN)) rd_nx[DATA_W-1:PIN_LSB] = oen_q;
    if (sel(addr_i, REG_STA)) rd_nx[DATA_W-1:PIN_LSB] = sta_q;
    if (sel(addr_i, REG_IN))  rd_nx[DATA_W-1:PIN_LSB] = pad_sync;
    for (int i = 0; i < int'(NUM_PINS); i++) begin
      if (sel(addr_i, REG_CFG0 + i)) begin
        rd_nx[CFG_WAKE_BIT]        = cfg_q[i].wake;
        rd_nx[CFG_TRIG_LSB +: 3]   = cfg_q[i].trig;
        rd_nx[CFG_OD_BIT]          = cfg_q[i].od;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_nx;
  end

  assign irq_o  = |sta_q;
  assign wake_o = |(sta_q & wake_en);

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && addr_i < ADDR_W'(REG_CFG0)) |-> (rdata_o[PIN_LSB-1:0] == '0)); // R1
  AST_OUT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel(addr_i, REG_OUT_SET)) |=> ((out_q & $past(wpins)) == $past(wpins))); // R2
  AST_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set) |=> ((sta_q & $past(hw_set)) == $past(hw_set))); // R12
  AST_WAKE_IMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o); // R11
endmodule

// File: tb/sim_lp_gpio_ctrl.sv
module sim_lp_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [21:0] pad_in = '0;
  logic [21:0] pad_out, pad_oe;
  logic        irq, wake;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  lp_gpio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic [31:0] pm(input int p);
    return 32'd1 << (10 + p);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = 6'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R2 out reset", v, 0);
    rd(3, v); chk("R3 oen reset", v, 0);
    rd(6, v); chk("R4 flag reset", v, 0);
    chk("R4 irq reset", {31'b0, irq}, 0);
    chk("R11 wake reset", {31'b0, wake}, 0);
    chk("R3 pad_oe reset", {10'b0, pad_oe}, 0);
  endtask

  task automatic t_out;
    logic [31:0] v;
    wr(0, 32'hA5A5_A5A5); rd(0, v); chk("R2 direct write", v, 32'hA5A5_A400);
    wr(1, 32'h0000_0C00); rd(0, v); chk("R2 set alias", v, 32'hA5A5_AC00);
    wr(2, 32'hA000_0000); rd(0, v); chk("R2 clear alias", v, 32'h05A5_AC00);
    chk("R2 pad_o follows", {10'b0, pad_out}, 32'h05A5_AC00 >> 10);
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R1 reserved bits", v, 32'hFFFF_FC00);
    wr(0, 0);
  endtask

  task automatic t_oen;
    logic [31:0] v;
    wr(3, 32'hFFFF_FFFF); rd(3, v); chk("R3 direct write", v, 32'hFFFF_FC00);
    wr(5, pm(0)); rd(3, v); chk("R3 clear alias", v, 32'hFFFF_F800);
    wr(4, pm(0)); rd(3, v); chk("R3 set alias", v, 32'hFFFF_FC00);
    chk("R3 pad_oe all", {10'b0, pad_oe}, 32'h003F_FFFF);
    wr(3, 0);
  endtask

  task automatic t_flag_sw;
    logic [31:0] v;
    wr(7, pm(1) | pm(2)); rd(6, v); chk("R4 set alias", v, pm(1) | pm(2));
    chk("R4 irq high", {31'b0, irq}, 1);
    wr(8, pm(1)); rd(6, v); chk("R4 clear alias", v, pm(2));
    wr(6, 0); rd(6, v); chk("R4 direct write", v, 0);
    chk("R4 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    wr(10 + 3, 32'd1 << 7);
    pad_in[3] = 1'b1; idle(4); rd(6, v); chk("R5 rise sets", v, pm(3));
    wr(8, pm(3)); pad_in[3] = 1'b0; idle(4); rd(6, v); chk("R5 rise ignores fall", v, 0);
    wr(10 + 3, 32'd2 << 7);
    pad_in[3] = 1'b1; idle(4); rd(6, v); chk("R5 fall ignores rise", v, 0);
    pad_in[3] = 1'b0; idle(4); rd(6, v); chk("R5 fall sets", v, pm(3));
    idle(3); rd(6, v); chk("R5 flag held", v, pm(3));
    wr(8, pm(3)); wr(10 + 3, 32'd3 << 7);
    pad_in[3] = 1'b1; idle(4); rd(6, v); chk("R5 any on rise", v, pm(3));
    wr(8, pm(3)); pad_in[3] = 1'b0; idle(4); rd(6, v); chk("R5 any on fall", v, pm(3));
    wr(10 + 3, 0); wr(8, pm(3));
  endtask

  task automatic t_levels;
    logic [31:0] v;
    wr(10 + 4, 32'd5 << 7);
    pad_in[4] = 1'b1; idle(4); wr(8, pm(4)); rd(6, v); chk("R6 high persists", v, pm(4));
    pad_in[4] = 1'b0; idle(4); wr(8, pm(4)); rd(6, v); chk("R6 high gone", v, 0);
    wr(10 + 4, 32'd4 << 7);
    idle(2); wr(8, pm(4)); rd(6, v); chk("R6 low persists", v, pm(4));
    pad_in[4] = 1'b1; idle(4); wr(8, pm(4)); rd(6, v); chk("R6 low gone", v, 0);
    wr(10 + 4, 0); pad_in[4] = 1'b0; idle(3);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 6 || c == 7) begin
        wr(10 + 7, 32'(c) << 7);
        pad_in[7] = 1'b1; idle(4); pad_in[7] = 1'b0; idle(4);
        rd(6, v); chk($sformatf("R7 code %0d silent", c), v, 0);
      end
    end
    wr(10 + 7, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(10 + 21, 32'hFFFF_FFFF); rd(10 + 21, v); chk("R9 cfg layout", v, 32'h0000_0784);
    wr(10 + 21, 0); rd(10 + 21, v); chk("R9 cfg cleared", v, 0);
  endtask

  task automatic t_drive;
    wr(10 + 5, 32'd1 << 2);
    wr(1, pm(5) | pm(6)); wr(4, pm(5) | pm(6));
    chk("R8 od releases on 1", {31'b0, pad_oe[5]}, 0);
    chk("R8 pp drives 1 oe", {31'b0, pad_oe[6]}, 1);
    chk("R8 pp drives 1 val", {31'b0, pad_out[6]}, 1);
    wr(2, pm(5));
    chk("R8 od pulls low oe", {31'b0, pad_oe[5]}, 1);
    chk("R8 od pulls low val", {31'b0, pad_out[5]}, 0);
    wr(10 + 5, 0); wr(0, 0); wr(3, 0);
  endtask

  task automatic t_input;
    logic [31:0] v;
    pad_in[9] = 1'b1;
    @(negedge clk);
    rd(9, v); chk("R10 not yet visible", v, 0);
    rd(9, v); chk("R10 visible after two", v, pm(9));
    pad_in[9] = 1'b0; idle(3);
  endtask

  task automatic t_wake;
    wr(10 + 2, 32'd1 << 10); wr(7, pm(2));
    chk("R11 wake with enable", {31'b0, wake}, 1);
    wr(10 + 2, 0);
    chk("R11 wake masked", {31'b0, wake}, 0);
    chk("R11 irq still high", {31'b0, irq}, 1);
    wr(8, pm(2));
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(10 + 8, 32'd1 << 7); wr(7, pm(8));
    pad_in[8] = 1'b1;
    idle(2);
    wr(8, pm(8));
    rd(6, v); chk("R12 hw set beats clear", v, pm(8));
    wr(8, pm(8)); rd(6, v); chk("R12 plain clear works", v, 0);
    wr(10 + 8, 0); pad_in[8] = 1'b0; idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_out; t_oen; t_flag_sw; t_edges; t_levels;
    t_disabled; t_cfg; t_drive; t_input; t_wake; t_race;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule